// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Controller

This block is the cache controller of one processor on a shared-bus multiprocessor. It holds a small direct-mapped cache of single-word lines. Each line carries one of three coherence states: Invalid, Shared (clean, possibly held by other caches) or Exclusive (dirty, owned only by this cache). Processor loads and stores are served from the cache where the state allows. Otherwise the controller asks an external arbiter for the bus and runs the needed transactions. A dirty victim is written back first, then a read miss or write miss is placed on the bus. The grant is held for the whole sequence, so each transaction is atomic.

The controller also watches the misses that other caches place on the bus. A snooped read miss that finds a local Exclusive copy makes the controller hand the word out on its supply port and keep the line as Shared. A snooped write miss removes the local copy. If that copy was dirty, the word is supplied first. Snoops are handled in any controller state, including while the controller waits for its own grant. Its own request is re-evaluated at grant time, so it sees the state the snoops left behind.

The processor request port follows valid/ready. A request is taken in the cycle where `cpu_req_valid` and `cpu_req_ready` are both high. After that, `cpu_req_ready` stays low, which is the busy indication, until the response cycle. The requester may hold `cpu_req_valid` high for as long as it likes. The response is a one-cycle `cpu_rsp_valid` pulse with no back-pressure. The bus side is plain control: `bus_req`/`bus_gnt` with the arbiter, and a command held until the responder raises `bus_ack`.

Top module: `snoop_inval_cache`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is high, and `bus_req`, `cpu_rsp_valid` and `sup_valid` are low. No snoop produces a supply, and the first access to any line goes to the bus.
- R2: A processor read of a Shared or Exclusive line with a matching tag returns the cached word with `cpu_rsp_valid` two cycles after acceptance, with no bus request.
- R3: A processor read that misses places command 2'b01 (read miss) with the request address on the bus. It returns `bus_rdata` taken in the acknowledged cycle, and leaves the line Shared.
- R4: On any processor miss whose victim line is Exclusive, the controller first issues command 2'b11 (write-back) with the victim address {old tag, index} and the victim word. The miss follows directly in the next bus cycle under the same grant.
- R5: A processor write to a Shared line with a matching tag places command 2'b10 (write miss) with the request address on the bus, then stores the new word and makes the line Exclusive.
- R6: A processor write to an Exclusive line with a matching tag updates the word with no bus request and responds two cycles after acceptance.
- R7: A processor write that misses places a write miss (2'b10) on the bus, ignores the returned data, and leaves the line Exclusive holding the written word.
- R8: A snooped read miss (2'b01) that hits a local Shared line produces no supply and leaves the line Shared.
- R9: A snooped read miss that hits a local Exclusive line raises `sup_valid` in the following cycle with the snooped address and the line's word, and downgrades the line to Shared.
- R10: A snooped write miss (2'b10) that hits a local Shared line invalidates it without a supply.
- R11: A snooped write miss that hits a local Exclusive line supplies the word on the next cycle as for R9 and then invalidates the line.
- R12: Snooped commands whose tag does not match the local line, idle (2'b00) and write-back (2'b11) commands change nothing and produce no supply. A supply appears only after a snooped miss.
- R13: `cpu_req_ready` is low from the cycle after acceptance until the response. Snoops arriving while the controller waits for its grant are applied, and the write-back decision is taken from the line state at grant time.
- R14: A non-idle `bus_cmd` appears only while `bus_req` and `bus_gnt` are both high, and it is held until `bus_ack`. The commands use the encoding 2'b00 idle, 2'b01 read miss, 2'b10 write miss and 2'b11 write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Controller can accept a request (low = busy) |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address: low bits index, high bits tag |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_rdata | output | DATA_W | Load data (store data echoed on stores) |
| bus_req | output | 1 | Request to the bus arbiter, held through the whole sequence |
| bus_gnt | input | 1 | Bus granted to this controller |
| bus_cmd | output | 2 | Command driven while owning the bus |
| bus_addr | output | ADDR_W | Address of the driven command |
| bus_wdata | output | DATA_W | Write-back word |
| bus_ack | input | 1 | Responder accepts the current command |
| bus_rdata | input | DATA_W | Fill word, valid with `bus_ack` of a miss |
| snp_cmd | input | 2 | Command seen on the bus from another master |
| snp_addr | input | ADDR_W | Address seen with `snp_cmd` |
| sup_valid | output | 1 | Controller supplies/writes back a dirty word |
| sup_addr | output | ADDR_W | Address of the supplied word |
| sup_data | output | DATA_W | Supplied word |

## Verification
Hits are due exactly two cycles after the accepting edge: one cycle for the lookup and one for the registered response. The bench counts negative edges from acceptance and requires the response on the second one. Bus commands appear one negative edge after the grant or after the previous command's acknowledge. The bench acknowledges each command when it samples it and compares the commands in order. The response then follows one cycle after the final acknowledge. A snoop response is due one cycle after the snoop is presented, so the bench samples `sup_valid` at the next negative edge. It then checks the line's new state through later processor accesses and snoops, using a model of the requirements.

// File: rtl/sic_pkg.sv
package sic_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHD = 2'b01,
    LS_EXC = 2'b10
  } line_st_e;

  typedef enum logic [1:0] {
    BC_IDLE   = 2'b00,
    BC_RDMISS = 2'b01,
    BC_WRMISS = 2'b10,
    BC_WBACK  = 2'b11
  } bus_cmd_e;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_LOOK,
    CS_WAIT,
    CS_WBACK,
    CS_FETCH
  } ctl_st_e;

endpackage

// File: rtl/sic_line_store.sv
module sic_line_store
  import sic_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  // processor port
  input  logic [IDX_W-1:0]  p_idx_i,
  output logic [1:0]        p_st_o,
  output logic [TAG_W-1:0]  p_tag_o,
  output logic [DATA_W-1:0] p_data_o,
  input  logic              p_we_i,
  input  logic [1:0]        p_wst_i,
  input  logic [TAG_W-1:0]  p_wtag_i,
  input  logic [DATA_W-1:0] p_wdata_i,
  // snoop port (state update only)
  input  logic [IDX_W-1:0]  s_idx_i,
  output logic [1:0]        s_st_o,
  output logic [TAG_W-1:0]  s_tag_o,
  output logic [DATA_W-1:0] s_data_o,
  input  logic              s_we_i,
  input  logic [1:0]        s_wst_i
);

  logic [1:0]        st_a  [LINES];
  logic [TAG_W-1:0]  tag_a [LINES];
  logic [DATA_W-1:0] dat_a [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [1:0]        st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] dat_q;
    logic              s_sel;
    logic              p_sel;

    assign s_sel = s_we_i && (s_idx_i == IDX_W'(g));
    assign p_sel = p_we_i && (p_idx_i == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q  <= LS_INV;
        tag_q <= '0;
        dat_q <= '0;
      end else if (s_sel) begin
        st_q <= s_wst_i;
      end else if (p_sel) begin
        st_q  <= p_wst_i;
        tag_q <= p_wtag_i;
        dat_q <= p_wdata_i;
      end
    end

    assign st_a[g]  = st_q;
    assign tag_a[g] = tag_q;
    assign dat_a[g] = dat_q;
  end

  assign p_st_o   = st_a[p_idx_i];
  assign p_tag_o  = tag_a[p_idx_i];
  assign p_data_o = dat_a[p_idx_i];
  assign s_st_o   = st_a[s_idx_i];
  assign s_tag_o  = tag_a[s_idx_i];
  assign s_data_o = dat_a[s_idx_i];

endmodule

// File: rtl/sic_snoop_unit.sv
module sic_snoop_unit
  import sic_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic [IDX_W-1:0]  idx_o,
  input  logic [1:0]        line_st_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              st_we_o,
  output logic [1:0]        st_wval_o,
  output logic              active_o,
  output logic              sup_valid_o,
  output logic [ADDR_W-1:0] sup_addr_o,
  output logic [DATA_W-1:0] sup_data_o
);

  logic is_rd, is_wr, tag_hit, dirty_hit, flush;

  assign idx_o     = snp_addr_i[IDX_W-1:0];
  assign is_rd     = (snp_cmd_i == BC_RDMISS);
  assign is_wr     = (snp_cmd_i == BC_WRMISS);
  assign active_o  = is_rd || is_wr;
  assign tag_hit   = (line_st_i != LS_INV) && (line_tag_i == snp_addr_i[ADDR_W-1:IDX_W]);
  assign dirty_hit = tag_hit && (line_st_i == LS_EXC);
  assign flush     = dirty_hit && active_o;

  // write miss: drop any copy; read miss: dirty owner downgrades
  assign st_we_o   = (tag_hit && is_wr) || (dirty_hit && is_rd);
  assign st_wval_o = is_wr ? LS_INV : LS_SHD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sup_valid_o <= 1'b0;
      sup_addr_o  <= '0;
      sup_data_o  <= '0;
    end else begin
      sup_valid_o <= flush;
      if (flush) begin
        sup_addr_o <= snp_addr_i;
        sup_data_o <= line_data_i;
      end
    end
  end

endmodule

// File: rtl/sic_proc_ctrl.sv
module sic_proc_ctrl
  import sic_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid_i,
  output logic              cpu_ready_o,
  input  logic              cpu_write_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_rsp_valid_o,
  output logic [DATA_W-1:0] cpu_rsp_data_o,
  input  logic              snp_active_i,
  output logic [IDX_W-1:0]  idx_o,
  input  logic [1:0]        line_st_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              we_o,
  output logic [1:0]        wst_o,
  output logic [TAG_W-1:0]  wtag_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);

  ctl_st_e st_q, st_d;
  logic              r_write;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  logic              rsp_set;
  logic [DATA_W-1:0] rsp_val;
  logic              tag_match, line_hit, victim_dirty;

  assign idx_o        = r_addr[IDX_W-1:0];
  assign wtag_o       = r_addr[ADDR_W-1:IDX_W];
  assign tag_match    = (line_tag_i == r_addr[ADDR_W-1:IDX_W]);
  assign line_hit     = (line_st_i != LS_INV) && tag_match;
  assign victim_dirty = (line_st_i == LS_EXC) && !tag_match;
  assign cpu_ready_o  = (st_q == CS_IDLE);

  always_comb begin
    st_d       = st_q;
    rsp_set    = 1'b0;
    rsp_val    = r_wdata;
    we_o       = 1'b0;
    wst_o      = LS_INV;
    wdata_o    = r_wdata;
    bus_req_o  = 1'b0;
    bus_cmd_o  = BC_IDLE;
    bus_addr_o = r_addr;
    bus_data_o = r_wdata;
    unique case (st_q)
      CS_IDLE: begin
        if (cpu_valid_i) st_d = CS_LOOK;
      end
      CS_LOOK: begin
        // a snoop owns the array this cycle; retry the lookup next cycle
        if (!snp_active_i) begin
          if (line_hit && !r_write) begin
            rsp_set = 1'b1;
            rsp_val = line_data_i;
            st_d    = CS_IDLE;
          end else if (line_hit && (line_st_i == LS_EXC)) begin
            we_o    = 1'b1;
            wst_o   = LS_EXC;
            rsp_set = 1'b1;
            st_d    = CS_IDLE;
          end else begin
            st_d = CS_WAIT;
          end
        end
      end
      CS_WAIT: begin
        bus_req_o = 1'b1;
        // victim decision taken here, after any snoops seen while waiting
        if (bus_gnt_i && !snp_active_i) st_d = victim_dirty ? CS_WBACK : CS_FETCH;
      end
      CS_WBACK: begin
        bus_req_o  = 1'b1;
        bus_cmd_o  = BC_WBACK;
        bus_addr_o = {line_tag_i, r_addr[IDX_W-1:0]};
        bus_data_o = line_data_i;
        if (bus_ack_i) st_d = CS_FETCH;
      end
      CS_FETCH: begin
        bus_req_o = 1'b1;
        bus_cmd_o = r_write ? BC_WRMISS : BC_RDMISS;
        if (bus_ack_i) begin
          we_o    = 1'b1;
          wst_o   = r_write ? LS_EXC : LS_SHD;
          wdata_o = r_write ? r_wdata : bus_rdata_i;
          rsp_set = 1'b1;
          rsp_val = r_write ? r_wdata : bus_rdata_i;
          st_d    = CS_IDLE;
        end
      end
      default: st_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q            <= CS_IDLE;
      r_write         <= 1'b0;
      r_addr          <= '0;
      r_wdata         <= '0;
      cpu_rsp_valid_o <= 1'b0;
      cpu_rsp_data_o  <= '0;
    end else begin
      st_q            <= st_d;
      cpu_rsp_valid_o <= rsp_set;
      if (rsp_set) cpu_rsp_data_o <= rsp_val;
      if (st_q == CS_IDLE && cpu_valid_i) begin
        r_write <= cpu_write_i;
        r_addr  <= cpu_addr_i;
        r_wdata <= cpu_wdata_i;
      end
    end
  end

endmodule

// File: rtl/snoop_inval_cache.sv
module snoop_inval_cache
  import sic_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              sup_valid,
  output logic [ADDR_W-1:0] sup_addr,
  output logic [DATA_W-1:0] sup_data
);

  logic [IDX_W-1:0]  p_idx_w, s_idx_w;
  logic [1:0]        p_st_w, s_st_w, p_wst_w, s_wst_w;
  logic [TAG_W-1:0]  p_tag_w, s_tag_w, p_wtag_w;
  logic [DATA_W-1:0] p_data_w, s_data_w, p_wdata_w;
  logic              p_we_w, s_we_w, snp_active_w;

  sic_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .p_idx_i   (p_idx_w),
    .p_st_o    (p_st_w),
    .p_tag_o   (p_tag_w),
    .p_data_o  (p_data_w),
    .p_we_i    (p_we_w),
    .p_wst_i   (p_wst_w),
    .p_wtag_i  (p_wtag_w),
    .p_wdata_i (p_wdata_w),
    .s_idx_i   (s_idx_w),
    .s_st_o    (s_st_w),
    .s_tag_o   (s_tag_w),
    .s_data_o  (s_data_w),
    .s_we_i    (s_we_w),
    .s_wst_i   (s_wst_w)
  );

  sic_snoop_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_snoop (
    .clk         (clk),
    .rst_n       (rst_n),
    .snp_cmd_i   (snp_cmd),
    .snp_addr_i  (snp_addr),
    .idx_o       (s_idx_w),
    .line_st_i   (s_st_w),
    .line_tag_i  (s_tag_w),
    .line_data_i (s_data_w),
    .st_we_o     (s_we_w),
    .st_wval_o   (s_wst_w),
    .active_o    (snp_active_w),
    .sup_valid_o (sup_valid),
    .sup_addr_o  (sup_addr),
    .sup_data_o  (sup_data)
  );

  sic_proc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .cpu_valid_i     (cpu_req_valid),
    .cpu_ready_o     (cpu_req_ready),
    .cpu_write_i     (cpu_req_write),
    .cpu_addr_i      (cpu_req_addr),
    .cpu_wdata_i     (cpu_req_wdata),
    .cpu_rsp_valid_o (cpu_rsp_valid),
    .cpu_rsp_data_o  (cpu_rsp_rdata),
    .snp_active_i    (snp_active_w),
    .idx_o           (p_idx_w),
    .line_st_i       (p_st_w),
    .line_tag_i      (p_tag_w),
    .line_data_i     (p_data_w),
    .we_o            (p_we_w),
    .wst_o           (p_wst_w),
    .wtag_o          (p_wtag_w),
    .wdata_o         (p_wdata_w),
    .bus_req_o       (bus_req),
    .bus_gnt_i       (bus_gnt),
    .bus_cmd_o       (bus_cmd),
    .bus_addr_o      (bus_addr),
    .bus_data_o      (bus_wdata),
    .bus_ack_i       (bus_ack),
    .bus_rdata_i     (bus_rdata)
  );

endmodule

// File: rtl/sic_checker.sv
module sic_checker #(
  parameter int ADDR_W = 8,
  parameter int TAG_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [1:0]        bus_cmd,
  input logic              bus_ack,
  input logic [1:0]        snp_cmd,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              sup_valid,
  input logic [1:0]        s_st,
  input logic [TAG_W-1:0]  s_tag
);

  assert_cmd_under_grant_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'b00) |-> (bus_req && bus_gnt));

  assert_busy_after_accept_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

  assert_miss_follows_wback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 2'b11 && bus_ack) |=> (bus_cmd == 2'b01 || bus_cmd == 2'b10));

  // covers R9 (read miss) and R11 (write miss) on a dirty local copy
  assert_dirty_snoop_supplies_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((snp_cmd == 2'b01 || snp_cmd == 2'b10) && s_st == 2'b10 &&
     s_tag == snp_addr[ADDR_W-1:ADDR_W-TAG_W]) |=> sup_valid);

  assert_supply_only_after_miss_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sup_valid |-> ($past(snp_cmd) == 2'b01 || $past(snp_cmd) == 2'b10));

endmodule

bind snoop_inval_cache sic_checker #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_ready (cpu_req_ready),
  .bus_req       (bus_req),
  .bus_gnt       (bus_gnt),
  .bus_cmd       (bus_cmd),
  .bus_ack       (bus_ack),
  .snp_cmd       (snp_cmd),
  .snp_addr      (snp_addr),
  .sup_valid     (sup_valid),
  .s_st          (s_st_w),
  .s_tag         (s_tag_w)
);

// File: tb/test_snoop_inval_cache.sv
module test_snoop_inval_cache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic        cpu_req_write = 1'b0;
  logic [7:0]  cpu_req_addr = '0;
  logic [31:0] cpu_req_wdata = '0;
  logic        cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic        bus_req;
  logic        bus_gnt = 1'b0;
  logic [1:0]  bus_cmd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic [1:0]  snp_cmd = 2'b00;
  logic [7:0]  snp_addr = '0;
  logic        sup_valid;
  logic [7:0]  sup_addr;
  logic [31:0] sup_data;

  always #4 clk = ~clk;

  snoop_inval_cache i_snoop_inval_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .sup_valid(sup_valid), .sup_addr(sup_addr),
    .sup_data(sup_data)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // model of the requirements: per-line state (0 I, 1 S, 2 E), tag, word; memory
  logic [1:0]  m_st [8];
  logic [4:0]  m_tg [8];
  logic [31:0] m_dt [8];
  logic [31:0] mem  [256];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic snp_predict(input logic [1:0] c, input logic [7:0] a,
                             output bit sup, output logic [31:0] d);
    logic [2:0] ix;
    bit hit;
    ix  = a[2:0];
    hit = (m_st[ix] != 2'd0) && (m_tg[ix] == a[7:3]);
    sup = hit && (m_st[ix] == 2'd2) && (c == 2'b01 || c == 2'b10);
    d   = m_dt[ix];
    if (sup) mem[a] = d;
    if (hit && c == 2'b10) m_st[ix] = 2'd0;
    else if (sup) m_st[ix] = 2'd1;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [7:0] a, input string rq);
    bit esup;
    logic [31:0] ed;
    @(negedge clk);
    snp_cmd  = c;
    snp_addr = a;
    snp_predict(c, a, esup, ed);
    @(negedge clk);
    snp_cmd = 2'b00;
    chk(sup_valid == esup, rq, "supply valid", 32'(sup_valid), 32'(esup));
    if (esup) begin
      chk(sup_addr == a, rq, "supply addr", 32'(sup_addr), 32'(a));
      chk(sup_data == ed, rq, "supply data", sup_data, ed);
    end
  endtask

  task automatic cpu_op(input bit wr, input logic [7:0] a, input logic [31:0] d,
                        input int gdelay, input bit inj, input logic [1:0] ic,
                        input logic [7:0] ia, input string rq);
    logic [2:0]  ix;
    bit hit, gobus, ewb, done, injected, spend, esup;
    int lat, ncmd, waitc, cyc;
    logic [7:0]  wba;
    logic [31:0] wbd, erd, sdat;
    ix = a[2:0];
    hit = (m_st[ix] != 2'd0) && (m_tg[ix] == a[7:3]);
    gobus = !(hit && (!wr || m_st[ix] == 2'd2));
    ewb = 1'b0; done = 1'b0; injected = 1'b0; spend = 1'b0; esup = 1'b0;
    lat = 0; ncmd = 0; waitc = 0; cyc = 0;
    wba = '0; wbd = '0; erd = '0; sdat = '0;
    if (!gobus) begin
      if (wr) m_dt[ix] = d;
      erd = m_dt[ix];
    end
    @(negedge clk);
    chk(cpu_req_ready == 1'b1, "R13", "ready before request", 32'(cpu_req_ready), 32'd1);
    cpu_req_valid = 1'b1;
    cpu_req_write = wr;
    cpu_req_addr  = a;
    cpu_req_wdata = d;
    @(posedge clk);
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
      lat++;
      if (lat == 1) begin
        cpu_req_valid = 1'b0;
        chk(cpu_req_ready == 1'b0, "R13", "busy after accept", 32'(cpu_req_ready), 32'd0);
      end
      if (spend) begin
        snp_cmd = 2'b00;
        spend = 1'b0;
        chk(sup_valid == esup, "R13", "snoop while waiting", 32'(sup_valid), 32'(esup));
      end
      if (cpu_rsp_valid) begin
        done    = 1'b1;
        bus_gnt = 1'b0;
        bus_ack = 1'b0;
        if (!wr) chk(cpu_rsp_rdata == erd, rq, "read data", cpu_rsp_rdata, erd);
      end else begin
        if (bus_cmd != 2'b00) begin
          if (ewb && ncmd == 0) begin
            chk(bus_cmd == 2'b11, "R4", "write-back cmd", 32'(bus_cmd), 32'd3);
            chk(bus_addr == wba, "R4", "write-back addr", 32'(bus_addr), 32'(wba));
            chk(bus_wdata == wbd, "R4", "write-back data", bus_wdata, wbd);
          end else begin
            chk(bus_cmd == (wr ? 2'b10 : 2'b01), rq, "miss cmd", 32'(bus_cmd), wr ? 32'd2 : 32'd1);
            chk(bus_addr == a, rq, "miss addr", 32'(bus_addr), 32'(a));
          end
          ncmd++;
          bus_ack   = 1'b1;
          bus_rdata = mem[bus_addr];
        end else begin
          bus_ack = 1'b0;
        end
        if (bus_req && !bus_gnt) begin
          if (inj && !injected) begin
            snp_cmd  = ic;
            snp_addr = ia;
            snp_predict(ic, ia, esup, sdat);
            injected = 1'b1;
            spend    = 1'b1;
          end else if (waitc >= gdelay) begin
            ewb = (m_st[ix] == 2'd2) && (m_tg[ix] != a[7:3]);
            wba = {m_tg[ix], ix};
            wbd = m_dt[ix];
            if (ewb) mem[wba] = wbd;
            erd      = mem[a];
            m_tg[ix] = a[7:3];
            m_st[ix] = wr ? 2'd2 : 2'd1;
            m_dt[ix] = wr ? d : mem[a];
            bus_gnt  = 1'b1;
          end else begin
            waitc++;
          end
        end
      end
    end
    chk(done, rq, "response arrived", 32'(done), 32'd1);
    if (!gobus) begin
      chk(lat == 2, rq, "hit latency", 32'(lat), 32'd2);
      chk(ncmd == 0, rq, "no bus on hit", 32'(ncmd), 32'd0);
    end else begin
      chk(ncmd == (ewb ? 2 : 1), rq, "bus command count", 32'(ncmd), ewb ? 32'd2 : 32'd1);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_st[i] = 2'd0; m_tg[i] = '0; m_dt[i] = '0;
    end
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 ^ (32'(i) * 32'h0001_0203);
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk(cpu_req_ready == 1'b1, "R1", "ready in reset", 32'(cpu_req_ready), 32'd1);
    chk(bus_req == 1'b0, "R1", "no bus request", 32'(bus_req), 32'd0);
    chk(cpu_rsp_valid == 1'b0, "R1", "no response", 32'(cpu_rsp_valid), 32'd0);
    chk(sup_valid == 1'b0, "R1", "no supply", 32'(sup_valid), 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) snoop(2'b10, 8'(i), "R1");

    // R3 then R2: fill every line by a read miss, then hit it
    for (int i = 0; i < 8; i++) begin
      cpu_op(1'b0, 8'(i), '0, 0, 1'b0, 2'b00, '0, "R3");
      cpu_op(1'b0, 8'(i), '0, 0, 1'b0, 2'b00, '0, "R2");
    end
    // R8: snooped read miss on a clean copy
    snoop(2'b01, 8'd5, "R8");
    cpu_op(1'b0, 8'd5, '0, 0, 1'b0, 2'b00, '0, "R8");

    // R5 upgrade, R6 dirty write and read-back
    for (int i = 0; i < 4; i++) begin
      cpu_op(1'b1, 8'(i), 32'h1000_0000 + 32'(i), 0, 1'b0, 2'b00, '0, "R5");
      cpu_op(1'b1, 8'(i), 32'h2000_0000 + 32'(i), 0, 1'b0, 2'b00, '0, "R6");
      cpu_op(1'b0, 8'(i), '0, 0, 1'b0, 2'b00, '0, "R6");
    end

    // R9: dirty copy supplied and downgraded
    snoop(2'b01, 8'd0, "R9");
    cpu_op(1'b0, 8'd0, '0, 0, 1'b0, 2'b00, '0, "R9");
    snoop(2'b01, 8'd0, "R9");
    cpu_op(1'b1, 8'd0, 32'h3000_0000, 0, 1'b0, 2'b00, '0, "R9");

    // R11 and R10: write-miss snoops on dirty and clean copies
    snoop(2'b10, 8'd1, "R11");
    cpu_op(1'b0, 8'd1, '0, 0, 1'b0, 2'b00, '0, "R11");
    snoop(2'b10, 8'd4, "R10");
    cpu_op(1'b0, 8'd4, '0, 0, 1'b0, 2'b00, '0, "R10");

    // R12: other tag, write-back and idle snoops change nothing
    snoop(2'b01, {5'd3, 3'd2}, "R12");
    snoop(2'b10, {5'd3, 3'd2}, "R12");
    snoop(2'b11, 8'd2, "R12");
    snoop(2'b00, 8'd2, "R12");
    cpu_op(1'b0, 8'd2, '0, 0, 1'b0, 2'b00, '0, "R12");

    // R7 with dirty victim (R4), then read miss over a dirty victim
    cpu_op(1'b1, {5'd1, 3'd2}, 32'hCAFE_0001, 0, 1'b0, 2'b00, '0, "R7");
    cpu_op(1'b0, {5'd2, 3'd2}, '0, 0, 1'b0, 2'b00, '0, "R4");
    cpu_op(1'b1, {5'd7, 3'd4}, 32'hCAFE_0002, 0, 1'b0, 2'b00, '0, "R7");

    // R13: snoops during the grant wait
    cpu_op(1'b1, 8'd5, 32'hBEEF_0005, 3, 1'b1, 2'b10, 8'd5, "R13");
    cpu_op(1'b0, {5'd4, 3'd3}, '0, 2, 1'b1, 2'b01, 8'd3, "R13");
    cpu_op(1'b1, {5'd6, 3'd5}, 32'hBEEF_0006, 1, 1'b1, 2'b10, 8'd5, "R13");

    // R14: sweep of mixed traffic over eight tags
    for (int i = 0; i < 96; i++) begin
      cpu_op((i % 3) == 1, 8'((i * 29 + 7) & 8'h3F), 32'(i) * 32'h0100_0193,
             i % 4, 1'b0, 2'b00, '0, "R14");
      if ((i % 5) == 0)
        snoop((i % 2) != 0 ? 2'b01 : 2'b10, 8'((i * 13) & 8'h3F), "R11");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule